// File: doc/BRIEF.md
# Inbound Window Address Translator

This block sits behind an inbound bus port and converts the addresses of requests that land in a 1 MB data window into 32-bit system-bus addresses. A second, 4 KB register window holds the configuration the conversion uses. Software programs it through a dedicated register port. Requests go in as a valid/address/write triple. After one clock, the translated address comes out with a valid strobe. A request that falls in neither window raises a one-cycle miss pulse instead.

Translation is controlled by two registers. The image control register carries an enable bit. The translation base register holds the system address that the start of the data window maps onto. With the enable bit clear, the window maps onto a fixed default base, which is zero by default, so window offset N reaches system address N. With the bit set, offset N reaches the programmed base plus N. A parameter can switch the block to a cheaper variant that only substitutes the upper address bits. The low part of the register window holds a small read-only identity header.

Top module: `win_xlate`

## Requirements
- R1: After reset, `out_valid`, `out_miss` and `cfg_rvalid` are 0, and both the control register (offset 0x110) and the translation base (offset 0x11C) read back as 0.
- R2: A request with `req_valid`=1 whose address lies in [DATA_BASE, DATA_BASE+0x100000) gives `out_valid`=1 in the next cycle, with `out_write` equal to the request's `req_write`.
- R3: With translation disabled, the output address is the default base {DEF_HI, 20'h0} plus the word-aligned window offset. With DEF_HI=0, offset N maps to system address N.
- R4: With control bit 2 set, the output address is the translation base plus the word-aligned window offset, taken modulo 2^32.
- R5: Bits [1:0] of the output address are always 0, whatever bits [1:0] of the request address are.
- R6: The control register at offset 0x110 keeps only bit 2 (the enable). It reads back as the written value ANDed with 0x4.
- R7: The translation base at offset 0x11C keeps bits [31:2] and reads back with bits [1:0] equal to 0.
- R8: Offset 0x000 reads the ID parameter and offset 0x010 reads DATA_BASE. Both are read-only. Every other offset in the register window reads 0 and ignores writes. Offset bits [1:0] are ignored.
- R9: A request whose address is outside both windows gives no `out_valid` and a one-cycle `out_miss` in the next cycle.
- R10: A request whose address lies in the register window [REG_BASE, REG_BASE+0x1000) gives neither `out_valid` nor `out_miss`.
- R11: A register write in the same cycle as a request does not affect that request. The next request uses the new value.
- R12: A register read (`cfg_valid`=1, `cfg_write`=0) gives `cfg_rvalid`=1 and the read data on `cfg_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Inbound request valid |
| req_addr | input | 32 | Inbound request byte address |
| req_write | input | 1 | Inbound request is a write |
| cfg_valid | input | 1 | Register access valid |
| cfg_write | input | 1 | Register access is a write |
| cfg_offset | input | 12 | Byte offset in the register window |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cfg_rvalid | output | 1 | Read data valid |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 32 | Translated system address |
| out_write | output | 1 | Write flag of the translated request |
| out_miss | output | 1 | Request hit neither window |

## Verification
The translation path is driven with offsets at the bottom, middle and top of the data window, with translation both disabled and enabled. This separates the identity mapping from the added base and shows that carries from the offset reach the upper bits. A base near the top of the address space checks wrap-around. Unaligned request addresses show that bits [1:0] are forced to zero. Addresses just below the data window, just past the register window, and inside the register window tell the three decode outcomes apart. A register write issued in the same cycle as a request shows which base value that request uses.

// File: rtl/win_xlate_pkg.sv
package win_xlate_pkg;

  localparam int XW_ADDR = 32;
  localparam int XW_DATA = 32;
  localparam int XW_WIN  = 20;
  localparam int XW_RWIN = 12;

  // word offsets (byte offset >> 2) inside the register window
  localparam logic [9:0] WO_ID    = 10'h000;
  localparam logic [9:0] WO_BASE  = 10'h004;
  localparam logic [9:0] WO_CTRL  = 10'h044;
  localparam logic [9:0] WO_XBASE = 10'h047;

  localparam int CTRL_EN_BIT = 2;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_REGS = 2'd2
  } region_e;

endpackage

// File: rtl/xlate_decode.sv
module xlate_decode
  import win_xlate_pkg::*;
#(
  parameter int                ADDR_W    = XW_ADDR,
  parameter int                WIN_BITS  = XW_WIN,
  parameter int                RWIN_BITS = XW_RWIN,
  parameter logic [ADDR_W-1:0] DATA_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] REG_BASE  = 32'h8010_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  logic data_hit;
  logic regs_hit;

  assign data_hit = (addr[ADDR_W-1:WIN_BITS]  == DATA_BASE[ADDR_W-1:WIN_BITS]);
  assign regs_hit = (addr[ADDR_W-1:RWIN_BITS] == REG_BASE[ADDR_W-1:RWIN_BITS]);

  always_comb begin
    if (data_hit) begin
      region = RGN_DATA;
    end else if (regs_hit) begin
      region = RGN_REGS;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/xlate_regfile.sv
module xlate_regfile
  import win_xlate_pkg::*;
#(
  parameter int                ADDR_W    = XW_ADDR,
  parameter int                DATA_W    = XW_DATA,
  parameter int                RWIN_BITS = XW_RWIN,
  parameter logic [DATA_W-1:0] DEV_ID    = 32'h1A2B_0001,
  parameter logic [ADDR_W-1:0] DATA_BASE = 32'h8000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  input  logic                 cfg_write,
  input  logic [RWIN_BITS-1:0] cfg_offset,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 cfg_rvalid,
  output logic                 xl_en,
  output logic [ADDR_W-1:0]    xl_base
);

  localparam int WORD_W = RWIN_BITS - 2;

  logic [WORD_W-1:0] word;
  logic              wr_ctrl;
  logic              wr_xbase;
  logic              rd_req;

  logic              en_q,    en_d;
  logic [ADDR_W-3:0] xbase_q, xbase_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;

  assign word     = cfg_offset[RWIN_BITS-1:2];
  assign wr_ctrl  = cfg_valid && cfg_write && (word == WORD_W'(WO_CTRL));
  assign wr_xbase = cfg_valid && cfg_write && (word == WORD_W'(WO_XBASE));
  assign rd_req   = cfg_valid && !cfg_write;

  // next-state
  always_comb begin
    en_d    = cfg_wdata[CTRL_EN_BIT];
    xbase_d = cfg_wdata[ADDR_W-1:2];
  end

  always_comb begin
    rdata_d = '0;
    if (word == WORD_W'(WO_ID)) begin
      rdata_d = DEV_ID;
    end else if (word == WORD_W'(WO_BASE)) begin
      rdata_d = DATA_W'(DATA_BASE);
    end else if (word == WORD_W'(WO_CTRL)) begin
      rdata_d[CTRL_EN_BIT] = en_q;
    end else if (word == WORD_W'(WO_XBASE)) begin
      rdata_d = DATA_W'({xbase_q, 2'b00});
    end
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xbase_q <= '0;
    end else if (wr_xbase) begin
      xbase_q <= xbase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
    end
  end

  assign cfg_rdata  = rdata_q;
  assign cfg_rvalid = rvalid_q;
  assign xl_en      = en_q;
  assign xl_base    = {xbase_q, 2'b00};

endmodule

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen
  import win_xlate_pkg::*;
#(
  parameter int                         ADDR_W   = XW_ADDR,
  parameter int                         WIN_BITS = XW_WIN,
  parameter bit                         ADD_MODE = 1'b1,
  parameter logic [ADDR_W-WIN_BITS-1:0] DEF_HI   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  region_e           region,
  input  logic              xl_en,
  input  logic [ADDR_W-1:0] xl_base,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output logic              out_miss
);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] addr_d;
  logic              hit;
  logic              miss;

  logic              valid_q;
  logic              miss_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;

  assign offset = {{(ADDR_W-WIN_BITS){1'b0}}, req_addr[WIN_BITS-1:2], 2'b00};
  assign base   = xl_en ? xl_base : {DEF_HI, {WIN_BITS{1'b0}}};

  generate
    if (ADD_MODE) begin : g_add
      // full-width base plus offset, wraps modulo 2^ADDR_W
      assign addr_d = base + offset;
    end else begin : g_subst
      // upper bits replaced, low bits straight from the offset
      assign addr_d = {base[ADDR_W-1:WIN_BITS], offset[WIN_BITS-1:0]};
    end
  endgenerate

  assign hit  = req_valid && (region == RGN_DATA);
  assign miss = req_valid && (region == RGN_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= hit;
      miss_q  <= miss;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
    end else if (hit) begin
      addr_q  <= addr_d;
      write_q <= req_write;
    end
  end

  assign out_valid = valid_q;
  assign out_miss  = miss_q;
  assign out_addr  = addr_q;
  assign out_write = write_q;

endmodule

// File: rtl/win_xlate.sv
module win_xlate
  import win_xlate_pkg::*;
#(
  parameter int                         ADDR_W    = XW_ADDR,
  parameter int                         DATA_W    = XW_DATA,
  parameter int                         WIN_BITS  = XW_WIN,
  parameter int                         RWIN_BITS = XW_RWIN,
  parameter int                         SYNC_STG  = 2,
  parameter bit                         ADD_MODE  = 1'b1,
  parameter logic [ADDR_W-1:0]          DATA_BASE = 32'h8000_0000,
  parameter logic [ADDR_W-1:0]          REG_BASE  = 32'h8010_0000,
  parameter logic [ADDR_W-WIN_BITS-1:0] DEF_HI    = '0,
  parameter logic [DATA_W-1:0]          DEV_ID    = 32'h1A2B_0001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic                 cfg_valid,
  input  logic                 cfg_write,
  input  logic [RWIN_BITS-1:0] cfg_offset,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic                 cfg_rvalid,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_write,
  output logic                 out_miss
);

  // asynchronous assert, synchronous release
  logic [SYNC_STG-1:0] rst_pipe;
  logic                rst_n_sync;

  generate
    genvar gi;
    for (gi = 0; gi < SYNC_STG; gi++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rst_pipe[gi] <= 1'b0;
        end else begin
          rst_pipe[gi] <= (gi == 0) ? 1'b1 : rst_pipe[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = rst_pipe[SYNC_STG-1];

  region_e           region;
  logic              xl_en;
  logic [ADDR_W-1:0] xl_base;

  xlate_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .RWIN_BITS (RWIN_BITS),
    .DATA_BASE (DATA_BASE),
    .REG_BASE  (REG_BASE)
  ) u_dec (
    .addr   (req_addr),
    .region (region)
  );

  xlate_regfile #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .RWIN_BITS (RWIN_BITS),
    .DEV_ID    (DEV_ID),
    .DATA_BASE (DATA_BASE)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_offset (cfg_offset),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cfg_rvalid (cfg_rvalid),
    .xl_en      (xl_en),
    .xl_base    (xl_base)
  );

  xlate_addr_gen #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .ADD_MODE (ADD_MODE),
    .DEF_HI   (DEF_HI)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_write (req_write),
    .region    (region),
    .xl_en     (xl_en),
    .xl_base   (xl_base),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_write (out_write),
    .out_miss  (out_miss)
  );

endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk #(
  parameter int                         ADDR_W   = 32,
  parameter int                         WIN_BITS = 20,
  parameter bit                         ADD_MODE = 1'b1,
  parameter logic [ADDR_W-WIN_BITS-1:0] DEF_HI   = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              cfg_valid,
  input logic              cfg_write,
  input logic              cfg_rvalid,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_write,
  input logic              out_miss,
  input logic              xl_en,
  input logic [ADDR_W-1:0] xl_base
);

  assert_write_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_write == $past(req_write)));

  assert_default_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(xl_en)) |->
      (out_addr == {DEF_HI, $past(req_addr[WIN_BITS-1:2]), 2'b00}));

  generate
    if (ADD_MODE) begin : g_add_chk
      assert_xlate_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(xl_en)) |->
          (out_addr == $past(xl_base) +
             {{(ADDR_W-WIN_BITS){1'b0}}, $past(req_addr[WIN_BITS-1:2]), 2'b00}));
    end else begin : g_sub_chk
      assert_xlate_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(xl_en)) |->
          (out_addr[ADDR_W-1:WIN_BITS] == $past(xl_base[ADDR_W-1:WIN_BITS])));
    end
  endgenerate

  assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[1:0] == 2'b00));

  assert_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_miss |-> !out_valid);

  assert_req_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_miss) |-> $past(req_valid));

  assert_read_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> $past(cfg_valid && !cfg_write));

endmodule

bind win_xlate win_xlate_chk #(
  .ADDR_W   (ADDR_W),
  .WIN_BITS (WIN_BITS),
  .ADD_MODE (ADD_MODE),
  .DEF_HI   (DEF_HI)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .cfg_valid  (cfg_valid),
  .cfg_write  (cfg_write),
  .cfg_rvalid (cfg_rvalid),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .out_write  (out_write),
  .out_miss   (out_miss),
  .xl_en      (xl_en),
  .xl_base    (xl_base)
);

// File: tb/sim_win_xlate.sv
`timescale 1ns/1ps
module sim_win_xlate;

  localparam logic [31:0] DBASE = 32'h8000_0000;
  localparam logic [31:0] RBASE = 32'h8010_0000;
  localparam logic [31:0] ID    = 32'h1A2B_0001;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_write;
  logic        cfg_valid;
  logic        cfg_write;
  logic [11:0] cfg_offset;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_write;
  logic        out_miss;

  int n_chk;
  int n_bad;
  bit finished;

  win_xlate u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .cfg_valid  (cfg_valid),
    .cfg_write  (cfg_write),
    .cfg_offset (cfg_offset),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .cfg_rvalid (cfg_rvalid),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_write  (out_write),
    .out_miss   (out_miss)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // request: drive at a falling edge, result visible at the next falling edge
  task automatic req(input logic [31:0] a, input logic w);
    req_valid = 1'b1;
    req_addr  = a;
    req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic reg_wr(input logic [11:0] ofs, input logic [31:0] d);
    cfg_valid  = 1'b1;
    cfg_write  = 1'b1;
    cfg_offset = ofs;
    cfg_wdata  = d;
    @(negedge clk);
    cfg_valid  = 1'b0;
    cfg_write  = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] ofs, output logic [31:0] d, output logic v);
    cfg_valid  = 1'b1;
    cfg_write  = 1'b0;
    cfg_offset = ofs;
    @(negedge clk);
    cfg_valid  = 1'b0;
    d = cfg_rdata;
    v = cfg_rvalid;
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] a, input logic w,
                            input logic [31:0] exp);
    req(a, w);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " miss"},  {31'b0, out_miss},  32'd0);
    check({tag, " addr"},  out_addr, exp);
    check({tag, " write"}, {31'b0, out_write}, {31'b0, w});
  endtask

  task automatic expect_reg(input string tag, input logic [11:0] ofs, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    reg_rd(ofs, d, v);
    check({tag, " rvalid"}, {31'b0, v}, 32'd1);
    check({tag, " rdata"},  d, exp);
  endtask

  task automatic t_reset;
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 out_miss", {31'b0, out_miss}, 32'd0);
    check("R1 cfg_rvalid", {31'b0, cfg_rvalid}, 32'd0);
    expect_reg("R1 ctrl", 12'h110, 32'h0);
    expect_reg("R1 xbase", 12'h11C, 32'h0);
    @(negedge clk);
    check("R12 rvalid idle", {31'b0, cfg_rvalid}, 32'd0);
  endtask

  task automatic t_disabled;
    expect_hit("R3 R2 low", DBASE, 1'b0, 32'h0000_0000);
    expect_hit("R3 mid", DBASE + 32'h1_2344, 1'b1, 32'h0001_2344);
    expect_hit("R3 top", DBASE + 32'hF_FFFC, 1'b0, 32'h000F_FFFC);
    expect_hit("R5 unaligned", DBASE + 32'h0_0103, 1'b1, 32'h0000_0100);
  endtask

  task automatic t_regs;
    reg_wr(12'h110, 32'hFFFF_FFFF);
    expect_reg("R6 ctrl mask", 12'h110, 32'h0000_0004);
    reg_wr(12'h110, 32'h0);
    expect_reg("R6 ctrl clear", 12'h110, 32'h0);
    reg_wr(12'h11C, 32'h4000_1003);
    expect_reg("R7 xbase", 12'h11C, 32'h4000_1000);
    expect_reg("R8 id", 12'h000, ID);
    expect_reg("R8 base", 12'h010, DBASE);
    expect_reg("R8 id byte ofs", 12'h002, ID);
    reg_wr(12'h114, 32'hFFFF_FFFF);
    expect_reg("R8 unimpl", 12'h114, 32'h0);
    reg_wr(12'h000, 32'h0);
    expect_reg("R8 id ro", 12'h000, ID);
    expect_reg("R8 hdr", 12'h004, 32'h0);
    expect_reg("R8 dev top", 12'h1F0, 32'h0);
    expect_reg("R8 far", 12'hFFC, 32'h0);
    expect_reg("R8 ctrl kept", 12'h110, 32'h0);
    expect_reg("R8 xbase kept", 12'h11C, 32'h4000_1000);
  endtask

  task automatic t_enabled;
    reg_wr(12'h110, 32'h4);
    expect_hit("R4 start", DBASE, 1'b1, 32'h4000_1000);
    expect_hit("R4 mid", DBASE + 32'h0_0FF0, 1'b0, 32'h4000_1FF0);
    expect_hit("R4 top", DBASE + 32'hF_FFFC, 1'b0, 32'h4010_0FFC);
    expect_hit("R4 R5 unaligned", DBASE + 32'h0_0011, 1'b0, 32'h4000_1010);
    reg_wr(12'h11C, 32'hFFFF_F000);
    expect_hit("R4 wrap", DBASE + 32'h0_2000, 1'b0, 32'h0000_1000);
    reg_wr(12'h11C, 32'h4000_1000);
  endtask

  task automatic t_same_cycle;
    // write and request in one cycle: request uses the old base
    req_valid  = 1'b1;
    req_addr   = DBASE + 32'h10;
    req_write  = 1'b0;
    cfg_valid  = 1'b1;
    cfg_write  = 1'b1;
    cfg_offset = 12'h11C;
    cfg_wdata  = 32'h5000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
    check("R11 old base", out_addr, 32'h4000_1010);
    expect_hit("R11 new base", DBASE + 32'h10, 1'b0, 32'h5000_0010);
    // disable in the same cycle as a request
    req_valid  = 1'b1;
    req_addr   = DBASE + 32'h20;
    cfg_valid  = 1'b1;
    cfg_write  = 1'b1;
    cfg_offset = 12'h110;
    cfg_wdata  = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
    check("R11 old enable", out_addr, 32'h5000_0020);
    expect_hit("R11 R3 disabled", DBASE + 32'h20, 1'b0, 32'h0000_0020);
  endtask

  task automatic t_miss;
    req(DBASE - 32'h4, 1'b0);
    check("R9 below valid", {31'b0, out_valid}, 32'd0);
    check("R9 below miss", {31'b0, out_miss}, 32'd1);
    @(negedge clk);
    check("R9 one cycle", {31'b0, out_miss}, 32'd0);
    req(RBASE + 32'h1000, 1'b1);
    check("R9 past regs miss", {31'b0, out_miss}, 32'd1);
    check("R9 past regs valid", {31'b0, out_valid}, 32'd0);
    req(RBASE + 32'h110, 1'b1);
    check("R10 regwin valid", {31'b0, out_valid}, 32'd0);
    check("R10 regwin miss", {31'b0, out_miss}, 32'd0);
    req(RBASE, 1'b0);
    check("R10 regwin base miss", {31'b0, out_miss}, 32'd0);
    @(negedge clk);
    check("R2 idle valid", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_write = 1'b0;
    cfg_valid = 1'b0;
    cfg_write = 1'b0;
    cfg_offset = '0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_disabled;
    t_regs;
    t_enabled;
    t_same_cycle;
    t_miss;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule